// File: doc/BRIEF.md
# ISA Configuration Register with Write Legalization

This block holds the machine ISA configuration register, one bit per letter extension, with bit n standing for the letter 'A'+n (A is bit 0, C bit 2, D bit 3, F bit 5, H bit 7, Q bit 16, V bit 21). Software writes arrive as a one-cycle strobe with data. Before the data reaches the register, the block legalizes it. A write that would switch off compressed support while the program counter sits on a 2-byte boundary is dropped whole. Extension bits that depend on one another are cleared from the written value when the bit they depend on is clear. Only the bits allowed by a static writable mask take the new value.

From the stored value the block derives the enables for the compressed sub-extensions: the base compressed set, its single- and double-precision load/store forms, the extra basic set, push/pop, and table jump. Each enable is also gated by a static implementation-support bit, so an enable for a sub-extension the implementation lacks stays low. A one-cycle pulse reports that an accepted write cleared the hypervisor bit, so the registers that hold hypervisor-only fields can drop them. A second one-cycle pulse reports that a write was accepted.

Top module: `isa_cfg_reg`

## Requirements
- R1: A strobed write whose data has bit 2 (C) at 0, while the stored bit 2 is 1 and `pc_bit1` is 1, is dropped whole: the register keeps its value and `wr_ok` stays low.
- R2: The written value is adjusted before merging. Bit 3 (D) is cleared if bit 5 (F) is 0. Then bits 16 (Q) and 21 (V) are cleared if the adjusted D is 0.
- R3: An accepted write stores (adjusted data AND `wmask`) OR (old value AND NOT `wmask`). Without an accepted write the register holds its value.
- R4: `sub_en[0]` (base compressed) is high when stored bit 2 is 1, or when `sup_letters[2]` is 0, and only if `sup_sub[0]` is 1.
- R5: `sub_en[1]` (single-precision forms) equals stored bit 5 AND `sub_en[0]` AND `sup_sub[1]`. `sub_en[2]` (double-precision forms) equals stored bit 3 AND `sub_en[0]` AND `sup_sub[2]`.
- R6: `sub_en[3]`, `sub_en[4]` and `sub_en[5]` (extra basic, push/pop, table jump) each equal `sub_en[0]` AND the matching `sup_sub` bit.
- R7: No `sub_en` bit is ever high while the matching `sup_sub` bit is 0.
- R8: `hyp_clr` is high for exactly the one cycle after an accepted write that takes stored bit 7 (H) from 1 to 0, and low otherwise.
- R9: `wr_ok` is high for exactly the one cycle after a strobed write that was not dropped by R1.
- R10: Reset loads the register with `sup_letters`. `wr_ok` and `hyp_clr` are low during and after reset until a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 26 | Write data, bit n = letter 'A'+n |
| pc_bit1 | input | 1 | Bit 1 of the current program counter |
| wmask | input | 26 | Static mask of writable bits |
| sup_letters | input | 26 | Static letter extensions the implementation has; reset value |
| sup_sub | input | 6 | Static sub-extension support: 0 base, 1 single, 2 double, 3 extra basic, 4 push/pop, 5 table jump |
| cfg_q | output | 26 | Stored register value |
| sub_en | output | 6 | Compressed sub-extension enables, same bit order as `sup_sub` |
| wr_ok | output | 1 | One-cycle pulse: write accepted |
| hyp_clr | output | 1 | One-cycle pulse: accepted write cleared H |

## Verification
On every cycle the assertions check several things. A dropped write leaves the register unchanged and raises no `wr_ok`. Masked bits never move. No sub-extension enable rises without support, and the floating-point forms never outrun the base enable. Each pulse traces back to a write in the cycle before. The bench's sweeps show the rest. They pass every combination of the C, D, F, Q, V and H data bits with both PC alignments, starting from a state with C and H set, so the bench can show that the dependency clearing is right and that the hypervisor pulse fires exactly on a 1-to-0 change. A sweep over all 64 support patterns, with and without C support, shows how each enable is derived.

// File: rtl/isa_cfg_reg.sv
module isa_cfg_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [25:0] wr_data,
  input  logic        pc_bit1,
  input  logic [25:0] wmask,
  input  logic [25:0] sup_letters,
  input  logic [5:0]  sup_sub,
  output logic [25:0] cfg_q,
  output logic [5:0]  sub_en,
  output logic        wr_ok,
  output logic        hyp_clr
);
  localparam int LC = 2;
  localparam int LD = 3;
  localparam int LF = 5;
  localparam int LH = 7;
  localparam int LQ = 16;
  localparam int LV = 21;

  logic [25:0] adj, nxt;
  logic        d_keep, reject, accept, zca;

  assign d_keep = wr_data[LD] & wr_data[LF];

  always_comb begin
    adj     = wr_data;
    adj[LD] = d_keep;
    adj[LQ] = wr_data[LQ] & d_keep;
    adj[LV] = wr_data[LV] & d_keep;
  end

  assign reject = ~wr_data[LC] & cfg_q[LC] & pc_bit1;
  assign accept = wr_en & ~reject;
  assign nxt    = (adj & wmask) | (cfg_q & ~wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= sup_letters;
      wr_ok   <= 1'b0;
      hyp_clr <= 1'b0;
    end else begin
      wr_ok   <= accept;
      hyp_clr <= accept & cfg_q[LH] & ~nxt[LH];
      if (accept) cfg_q <= nxt;
    end
  end

  assign zca    = (cfg_q[LC] | ~sup_letters[LC]) & sup_sub[0];
  assign sub_en = {zca & sup_sub[5],
                   zca & sup_sub[4],
                   zca & sup_sub[3],
                   cfg_q[LD] & zca & sup_sub[2],
                   cfg_q[LF] & zca & sup_sub[1],
                   zca};

  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[LC] && cfg_q[LC] && pc_bit1) |=> ($stable(cfg_q) && !wr_ok)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)); // R3
  AST_MASKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((cfg_q ^ $past(cfg_q)) & ~$past(wmask)) == 26'd0)); // R3
  AST_FP_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en[1] || sub_en[2]) |-> sub_en[0]); // R5
  AST_SUB_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((sub_en & ~sup_sub) == 6'd0)); // R7
  AST_HCLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_clr |-> ($past(cfg_q[LH]) && !cfg_q[LH] && $past(wr_en))); // R8
  AST_WROK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> $past(wr_en)); // R9
endmodule

// File: tb/tb_isa_cfg_reg.sv
`timescale 1ns/1ps
module tb_isa_cfg_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [25:0] wr_data = '0;
  logic        pc_bit1 = 1'b0;
  logic [25:0] wmask = '1;
  logic [25:0] sup_letters = '1;
  logic [5:0]  sup_sub = '1;
  logic [25:0] cfg_q;
  logic [5:0]  sub_en;
  logic        wr_ok, hyp_clr;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [25:0] m;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  isa_cfg_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pc_bit1(pc_bit1),
    .wmask(wmask), .sup_letters(sup_letters), .sup_sub(sup_sub),
    .cfg_q(cfg_q), .sub_en(sub_en), .wr_ok(wr_ok), .hyp_clr(hyp_clr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextr(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [25:0] fix(input logic [25:0] x);
    logic [25:0] y;
    y = x;
    if (!y[5]) y[3] = 1'b0;
    if (!y[3]) begin y[16] = 1'b0; y[21] = 1'b0; end
    return y;
  endfunction

  task automatic check_sub();
    logic za;
    za = (m[2] || !sup_letters[2]) && sup_sub[0];
    chk(sub_en[0] == za, "R4", {31'd0, sub_en[0]}, {31'd0, za});
    chk(sub_en[1] == (m[5] && za && sup_sub[1]), "R5", {31'd0, sub_en[1]}, {31'd0, m[5] && za && sup_sub[1]});
    chk(sub_en[2] == (m[3] && za && sup_sub[2]), "R5", {31'd0, sub_en[2]}, {31'd0, m[3] && za && sup_sub[2]});
    chk(sub_en[5:3] == ({3{za}} & sup_sub[5:3]), "R6", {29'd0, sub_en[5:3]}, {29'd0, {3{za}} & sup_sub[5:3]});
    chk((sub_en & ~sup_sub) == 6'd0, "R7", {26'd0, sub_en}, {26'd0, sup_sub});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(posedge clk); #1;
    m = sup_letters;
    chk(cfg_q == m, "R10", {6'd0, cfg_q}, {6'd0, m});
    chk(!wr_ok && !hyp_clr, "R10", {30'd0, wr_ok, hyp_clr}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(cfg_q == m, "R10", {6'd0, cfg_q}, {6'd0, m});
    chk(!wr_ok && !hyp_clr, "R10", {30'd0, wr_ok, hyp_clr}, 32'd0);
  endtask

  task automatic do_wr(input logic [25:0] x, input logic p);
    logic rej, hx;
    logic [25:0] nm;
    rej = !x[2] && m[2] && p;
    nm  = rej ? m : ((fix(x) & wmask) | (m & ~wmask));
    hx  = !rej && m[7] && !nm[7];
    @(negedge clk);
    wr_en = 1'b1; wr_data = x; pc_bit1 = p;
    @(posedge clk); #1;
    chk(cfg_q == nm, rej ? "R1" : "R3", {6'd0, cfg_q}, {6'd0, nm});
    if (!rej && wmask == '1)
      chk({cfg_q[21], cfg_q[16], cfg_q[3]} == {nm[21], nm[16], nm[3]}, "R2",
          {29'd0, cfg_q[21], cfg_q[16], cfg_q[3]}, {29'd0, nm[21], nm[16], nm[3]});
    chk(wr_ok == !rej, "R9", {31'd0, wr_ok}, {31'd0, !rej});
    chk(hyp_clr == hx, "R8", {31'd0, hyp_clr}, {31'd0, hx});
    m = nm;
    check_sub();
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk); #1;
    chk(!wr_ok, "R9", {31'd0, wr_ok}, 32'd0);
    chk(!hyp_clr, "R8", {31'd0, hyp_clr}, 32'd0);
    chk(cfg_q == m, "R3", {6'd0, cfg_q}, {6'd0, m});
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [25:0] x;
    do_reset();
    check_sub();
    // full sweep of key bits, both PC alignments, from a C=1,H=1 state
    for (int s = 0; s < 128; s++) begin
      do_wr(26'h3FF_FFFF, 1'b0);
      rng = nextr(rng);
      x = rng[25:0];
      x[2] = s[0]; x[3] = s[1]; x[5] = s[2]; x[16] = s[3]; x[21] = s[4]; x[7] = s[5];
      do_wr(x, s[6]);
    end
    // partial writable mask
    for (int i = 0; i < 64; i++) begin
      rng = nextr(rng);
      wmask = rng[31:6];
      rng = nextr(rng);
      do_wr(rng[25:0], rng[31]);
    end
    wmask = '1;
    // support vector sweep, with and without C support
    for (int s = 0; s < 128; s++) begin
      sup_letters[2] = s[6];
      sup_sub = s[5:0];
      rng = nextr(rng);
      do_wr(rng[25:0], 1'b0);
    end
    // reset value follows the support vector
    sup_letters = 26'h2A5_5A5A;
    sup_sub = 6'h3F;
    do_reset();
    check_sub();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule